// File: doc/BRIEF.md
# Fixed-Vector Interrupt Entry Unit

This block sits next to the program counter of a small processor core and turns hardware interrupt requests into control transfers. Six request lines come in: two external pins, three timers and one serial port. When the global enable is on, at least one request is pending with its own enable bit set, and the core reports an instruction boundary, the unit picks the most urgent source. It saves the address of the next instruction and then loads that source's hard-wired code address into the program counter. The core fetches the service routine straight from that address. No table word is read.

The return address is saved in one of two ways, chosen when the interrupt is taken. In stack mode it is pushed as two bytes through a byte-wide memory port, addressed by a stack pointer held inside the unit. In link mode it is copied into an internal link register and memory is not touched. While a routine is running, new entries are held off. A return strobe brings the saved address back into the program counter, and interrupt entry is then re-armed.

Top module: `irq_entry_unit`

## Requirements
- R1: While reset is asserted, `pc_load`, `stk_we`, `stk_re` and `isr_active` are 0 and `sp_out` equals `SP_INIT` (0x07 by default).
- R2: An entry is taken only when `insn_boundary` is 1, `glob_en` is 1, the source's bit in `irq_en` is 1, its bit in `irq_req` is 1 and no routine is active. Otherwise the unit makes no stack access and no `pc_load` pulse.
- R3: Request bit positions are: bit 0 external pin 0, bit 1 timer 0, bit 2 external pin 1, bit 3 timer 1, bit 4 serial, bit 5 timer 2. Among enabled pending requests, the lowest bit position wins.
- R4: The entry address loaded for bit i is `VEC_BASE + i*VEC_STRIDE`, so the defaults give 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 and 0x002B, each an 8-byte code slot.
- R5: In stack mode (`link_mode`=0 when the entry is taken) the unit writes to memory in the first cycle after the accepting edge and again in the second. The first write puts the low PC byte at SP+1 and the second puts the high byte at SP+2. In the third cycle `pc_load` is 1 with the vector on `pc_out`.
- R6: In link mode the unit drives `pc_load` with the vector in the first cycle after the accepting edge. It keeps the interrupted PC internally and makes no stack access for that entry or its return.
- R7: While `isr_active` is 1, further requests and boundaries start no new entry. `pc_load` is never 1 in two consecutive cycles.
- R8: A return in stack mode reads the high byte at SP and then the low byte at SP-1, in the first and second cycles after the strobe. In the third cycle `pc_out` carries the restored PC with `pc_load`=1, and SP is back at its value before the entry.
- R9: A return in link mode drives `pc_load` with the saved PC in the first cycle after the strobe.
- R10: A return strobe while no routine is active causes no stack read and no `pc_load` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 6 | Interrupt request lines, bit order as in R3 |
| irq_en | input | 6 | Per-source enables |
| glob_en | input | 1 | Global interrupt enable |
| insn_boundary | input | 1 | Core is between instructions |
| link_mode | input | 1 | 1: save return PC in link register; 0: push to stack |
| reti | input | 1 | Return-from-interrupt strobe |
| pc_in | input | 16 | Address of the next instruction |
| pc_load | output | 1 | One-cycle strobe: core takes `pc_out` as its PC |
| pc_out | output | 16 | Vector on entry, restored PC on return |
| stk_we | output | 1 | Stack byte write |
| stk_re | output | 1 | Stack byte read (data expected next cycle) |
| stk_addr | output | 8 | Stack byte address, equal to the stack pointer |
| stk_wdata | output | 8 | Byte to write |
| stk_rdata | input | 8 | Byte read, one cycle after `stk_re` |
| sp_out | output | 8 | Current stack pointer |
| isr_active | output | 1 | Entry, routine or return in progress |

## Verification
Every result has a fixed latency, counted from the clock edge that samples the stimulus. In stack mode the two byte writes come one and two cycles after that edge and the vector three cycles after it. In link mode the vector comes one cycle after. A stack return puts its reads one and two cycles after the strobe's edge and the restored PC three cycles after. A link return restores one cycle after. The bench drives and samples on falling edges and steps exactly that many cycles before each comparison, so every check lands in the single cycle where the result is due. The negative cases (masked, blocked, idle return) watch the outputs for several cycles in which nothing may move.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_LOAD_VEC,
    ST_ACTIVE,
    ST_POP_HI,
    ST_POP_LO,
    ST_RESTORE
  } ent_state_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int NUM_SRC = 6,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] en,
  input  logic               glob_en,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);

  logic [NUM_SRC-1:0] masked;
  logic [NUM_SRC-1:0] grant;

  assign masked = req & en & {NUM_SRC{glob_en}};
  assign hit    = |masked;

  // lowest bit position has the highest urgency
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_grant
    if (i == 0) begin : g_first
      assign grant[i] = masked[0];
    end else begin : g_rest
      assign grant[i] = masked[i] & ~(|masked[i-1:0]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
  parameter int NUM_SRC    = 6,
  parameter int PC_W       = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [IDX_W-1:0] idx,
  output logic [PC_W-1:0]  vec
);

  logic [PC_W-1:0] slot [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    assign slot[i] = PC_W'(VEC_BASE + i * VEC_STRIDE);
  end

  always_comb begin
    vec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (idx == IDX_W'(i)) vec = slot[i];
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int SP_W    = 8,
  parameter int SP_INIT = 7,
  localparam int HI_W   = PC_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              insn_boundary,
  input  logic              link_mode,
  input  logic              reti,
  input  logic [PC_W-1:0]   vec_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [BYTE_W-1:0] stk_rdata,
  output logic              stk_we,
  output logic              stk_re,
  output logic [SP_W-1:0]   stk_addr,
  output logic [BYTE_W-1:0] stk_wdata,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_out,
  output logic [SP_W-1:0]   sp_out,
  output logic              busy,
  output logic              vec_load,
  output logic              via_link
);

  ent_state_t      state_q, state_n;
  logic [PC_W-1:0] link_q;
  logic [PC_W-1:0] vec_q;
  logic [HI_W-1:0] hi_q;
  logic            mode_q;
  logic [SP_W-1:0] sp_q, sp_n;

  logic take;
  logic save_en;
  logic sp_en;
  logic hi_en;

  assign take    = hit && insn_boundary && (state_q == ST_IDLE);
  assign save_en = take;
  assign hi_en   = (state_q == ST_POP_LO);

  // next state
  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:     if (take) state_n = link_mode ? ST_LOAD_VEC : ST_PUSH_LO;
      ST_PUSH_LO:  state_n = ST_PUSH_HI;
      ST_PUSH_HI:  state_n = ST_LOAD_VEC;
      ST_LOAD_VEC: state_n = ST_ACTIVE;
      ST_ACTIVE:   if (reti) state_n = mode_q ? ST_RESTORE : ST_POP_HI;
      ST_POP_HI:   state_n = ST_POP_LO;
      ST_POP_LO:   state_n = ST_RESTORE;
      ST_RESTORE:  state_n = ST_IDLE;
      default:     state_n = ST_IDLE;
    endcase
  end

  // stack pointer: pre-increment on push, post-decrement on pop
  always_comb begin
    sp_en = 1'b0;
    sp_n  = sp_q;
    if ((take && !link_mode) || (state_q == ST_PUSH_LO)) begin
      sp_en = 1'b1;
      sp_n  = sp_q + SP_W'(1);
    end else if ((state_q == ST_POP_HI) || (state_q == ST_POP_LO)) begin
      sp_en = 1'b1;
      sp_n  = sp_q - SP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sp_q    <= SP_W'(SP_INIT);
      link_q  <= '0;
      vec_q   <= '0;
      hi_q    <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      if (sp_en) sp_q <= sp_n;
      if (save_en) begin
        link_q <= pc_in;
        vec_q  <= vec_in;
        mode_q <= link_mode;
      end
      if (hi_en) hi_q <= stk_rdata[HI_W-1:0];
    end
  end

  // outputs
  assign stk_we    = (state_q == ST_PUSH_LO) || (state_q == ST_PUSH_HI);
  assign stk_re    = (state_q == ST_POP_HI)  || (state_q == ST_POP_LO);
  assign stk_addr  = sp_q;
  assign stk_wdata = (state_q == ST_PUSH_LO) ? link_q[BYTE_W-1:0]
                                             : BYTE_W'(link_q[PC_W-1:BYTE_W]);
  assign vec_load  = (state_q == ST_LOAD_VEC);
  assign pc_load   = vec_load || (state_q == ST_RESTORE);
  assign busy      = (state_q != ST_IDLE);
  assign via_link  = busy && mode_q;
  assign sp_out    = sp_q;

  always_comb begin
    if (vec_load)    pc_out = vec_q;
    else if (mode_q) pc_out = link_q;
    else             pc_out = {hi_q, stk_rdata};
  end

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit #(
  parameter int NUM_SRC    = 6,
  parameter int PC_W       = 16,
  parameter int SP_W       = 8,
  parameter int SP_INIT    = 7,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic               glob_en,
  input  logic               insn_boundary,
  input  logic               link_mode,
  input  logic               reti,
  input  logic [PC_W-1:0]    pc_in,
  output logic               pc_load,
  output logic [PC_W-1:0]    pc_out,
  output logic               stk_we,
  output logic               stk_re,
  output logic [SP_W-1:0]    stk_addr,
  output logic [7:0]         stk_wdata,
  input  logic [7:0]         stk_rdata,
  output logic [SP_W-1:0]    sp_out,
  output logic               isr_active
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [1:0]       rst_sync;
  logic             rst_s;
  logic             hit;
  logic [IDX_W-1:0] src_idx;
  logic [PC_W-1:0]  vec;
  logic             vec_load;
  logic             via_link;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  irq_prio_sel #(.NUM_SRC(NUM_SRC)) u_prio (
    .req     (irq_req),
    .en      (irq_en),
    .glob_en (glob_en),
    .hit     (hit),
    .idx     (src_idx)
  );

  irq_vec_gen #(
    .NUM_SRC    (NUM_SRC),
    .PC_W       (PC_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_vec (
    .idx (src_idx),
    .vec (vec)
  );

  irq_entry_seq #(
    .PC_W    (PC_W),
    .SP_W    (SP_W),
    .SP_INIT (SP_INIT)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_s),
    .hit           (hit),
    .insn_boundary (insn_boundary),
    .link_mode     (link_mode),
    .reti          (reti),
    .vec_in        (vec),
    .pc_in         (pc_in),
    .stk_rdata     (stk_rdata),
    .stk_we        (stk_we),
    .stk_re        (stk_re),
    .stk_addr      (stk_addr),
    .stk_wdata     (stk_wdata),
    .pc_load       (pc_load),
    .pc_out        (pc_out),
    .sp_out        (sp_out),
    .busy          (isr_active),
    .vec_load      (vec_load),
    .via_link      (via_link)
  );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int PC_W       = 16,
  parameter int SP_W       = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stk_we,
  input logic            stk_re,
  input logic [SP_W-1:0] stk_addr,
  input logic            pc_load,
  input logic [PC_W-1:0] pc_out,
  input logic            isr_active,
  input logic            vec_load,
  input logic            via_link
);

  // R2: idle means no stack traffic and no PC load
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !isr_active |-> (!stk_we && !stk_re && !pc_load));

  // R4: an entry load always lands on a code slot
  a_r4_vec_slot: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |-> (pc_load &&
      (((pc_out - PC_W'(VEC_BASE)) % PC_W'(VEC_STRIDE)) == '0)));

  // R5: two writes at rising addresses
  a_r5_push_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_we) |=> (stk_we && (stk_addr == $past(stk_addr) + SP_W'(1))));

  // R5: vector is loaded right after the second write
  a_r5_vec_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stk_we) |-> vec_load);

  // R6: link mode never touches memory
  a_r6_link_no_stack: assert property (@(posedge clk) disable iff (!rst_n)
    via_link |-> (!stk_we && !stk_re));

  // R7: PC load is a single-cycle strobe
  a_r7_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);

  // R8: two reads at falling addresses
  a_r8_pop_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_re) |=> (stk_re && (stk_addr == $past(stk_addr) - SP_W'(1))));

endmodule

bind irq_entry_unit irq_entry_chk #(
  .PC_W       (PC_W),
  .SP_W       (SP_W),
  .VEC_BASE   (VEC_BASE),
  .VEC_STRIDE (VEC_STRIDE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_s),
  .stk_we     (stk_we),
  .stk_re     (stk_re),
  .stk_addr   (stk_addr),
  .pc_load    (pc_load),
  .pc_out     (pc_out),
  .isr_active (isr_active),
  .vec_load   (vec_load),
  .via_link   (via_link)
);

// File: tb/tb_irq_entry_unit.sv
`timescale 1ns/1ps
module tb_irq_entry_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  irq_req;
  logic [5:0]  irq_en;
  logic        glob_en;
  logic        insn_boundary;
  logic        link_mode;
  logic        reti;
  logic [15:0] pc_in;
  logic        pc_load;
  logic [15:0] pc_out;
  logic        stk_we;
  logic        stk_re;
  logic [7:0]  stk_addr;
  logic [7:0]  stk_wdata;
  logic [7:0]  stk_rdata;
  logic [7:0]  sp_out;
  logic        isr_active;

  logic [7:0] mem [256];

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  irq_entry_unit dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_req       (irq_req),
    .irq_en        (irq_en),
    .glob_en       (glob_en),
    .insn_boundary (insn_boundary),
    .link_mode     (link_mode),
    .reti          (reti),
    .pc_in         (pc_in),
    .pc_load       (pc_load),
    .pc_out        (pc_out),
    .stk_we        (stk_we),
    .stk_re        (stk_re),
    .stk_addr      (stk_addr),
    .stk_wdata     (stk_wdata),
    .stk_rdata     (stk_rdata),
    .sp_out        (sp_out),
    .isr_active    (isr_active)
  );

  // byte memory with one-cycle read latency
  always @(posedge clk) begin
    if (stk_we) mem[stk_addr] <= stk_wdata;
    if (stk_re) stk_rdata <= mem[stk_addr];
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    irq_req = '0; irq_en = '0; glob_en = 1'b0; insn_boundary = 1'b0;
    link_mode = 1'b0; reti = 1'b0; pc_in = '0;
    step(); step();
    chk("R1 pc_load", int'(pc_load), 0);
    chk("R1 stk_we", int'(stk_we), 0);
    chk("R1 stk_re", int'(stk_re), 0);
    chk("R1 isr_active", int'(isr_active), 0);
    chk("R1 sp_out", int'(sp_out), 8'h07);
    rst_n = 1'b1;
    step(); step(); step();
  endtask

  // stack-mode entry, blocked re-entry, then stack return
  task automatic t_stack(input logic [5:0] req, input logic [15:0] pc, input logic [15:0] vec);
    irq_req = req; irq_en = 6'h3F; glob_en = 1'b1; link_mode = 1'b0;
    pc_in = pc; insn_boundary = 1'b1;
    step();
    chk("R5 first write", int'(stk_we), 1);
    chk("R5 first addr", int'(stk_addr), 8'h08);
    chk("R5 low byte", int'(stk_wdata), int'(pc[7:0]));
    chk("R5 no load yet", int'(pc_load), 0);
    insn_boundary = 1'b0;
    step();
    chk("R5 second write", int'(stk_we), 1);
    chk("R5 second addr", int'(stk_addr), 8'h09);
    chk("R5 high byte", int'(stk_wdata), int'(pc[15:8]));
    step();
    chk("R5 vector load", int'(pc_load), 1);
    chk("R3 R4 vector", int'(pc_out), int'(vec));
    chk("R5 write done", int'(stk_we), 0);
    step();
    // R7: requests during the routine are held off
    irq_req = 6'h3F; insn_boundary = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R7 no reentry load", int'(pc_load), 0);
      chk("R7 no reentry write", int'(stk_we), 0);
      chk("R7 still active", int'(isr_active), 1);
    end
    insn_boundary = 1'b0; irq_req = '0;
    chk("R5 mem low", int'(mem[8]), int'(pc[7:0]));
    chk("R5 mem high", int'(mem[9]), int'(pc[15:8]));
    reti = 1'b1;
    step();
    reti = 1'b0;
    chk("R8 first read", int'(stk_re), 1);
    chk("R8 high addr", int'(stk_addr), 8'h09);
    step();
    chk("R8 second read", int'(stk_re), 1);
    chk("R8 low addr", int'(stk_addr), 8'h08);
    step();
    chk("R8 restore load", int'(pc_load), 1);
    chk("R8 restored pc", int'(pc_out), int'(pc));
    chk("R8 sp back", int'(sp_out), 8'h07);
    step();
    chk("R8 idle again", int'(isr_active), 0);
  endtask

  // link-mode entry and return
  task automatic t_link(input logic [5:0] req, input logic [5:0] en,
                        input logic [15:0] pc, input logic [15:0] vec);
    irq_req = req; irq_en = en; glob_en = 1'b1; link_mode = 1'b1;
    pc_in = pc; insn_boundary = 1'b1;
    step();
    chk("R6 vector load", int'(pc_load), 1);
    chk("R6 R3 R4 vector", int'(pc_out), int'(vec));
    chk("R6 no write", int'(stk_we), 0);
    insn_boundary = 1'b0; irq_req = '0; pc_in = 16'hFFFF;
    step();
    chk("R6 no access", int'(stk_we | stk_re), 0);
    reti = 1'b1;
    step();
    reti = 1'b0;
    chk("R9 restore load", int'(pc_load), 1);
    chk("R9 restored pc", int'(pc_out), int'(pc));
    chk("R6 no read", int'(stk_re), 0);
    step();
    chk("R6 sp untouched", int'(sp_out), 8'h07);
    chk("R9 idle again", int'(isr_active), 0);
    link_mode = 1'b0;
  endtask

  task automatic t_masked();
    irq_req = 6'h3F; pc_in = 16'h5555;
    glob_en = 1'b0; irq_en = 6'h3F; insn_boundary = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R2 global off", int'({isr_active, pc_load, stk_we}), 0);
    end
    glob_en = 1'b1; irq_en = 6'h00;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R2 source off", int'({isr_active, pc_load, stk_we}), 0);
    end
    irq_en = 6'h3F; insn_boundary = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R2 no boundary", int'({isr_active, pc_load, stk_we}), 0);
    end
    irq_req = '0;
  endtask

  task automatic t_reti_idle();
    reti = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R10 no read", int'(stk_re), 0);
      chk("R10 no load", int'(pc_load), 0);
    end
    reti = 1'b0;
    step();
    chk("R10 sp same", int'(sp_out), 8'h07);
  endtask

  initial begin
    t_reset();
    t_stack(6'b101100, 16'h1234, 16'h0013);
    t_stack(6'b110000, 16'hBEEF, 16'h0023);
    t_link(6'b000011, 6'b111110, 16'h0ABC, 16'h000B);
    t_link(6'b100000, 6'h3F, 16'h4321, 16'h002B);
    t_link(6'b001001, 6'h3F, 16'h7001, 16'h0003);
    t_stack(6'b001000, 16'h8642, 16'h001B);
    t_masked();
    t_reti_idle();
    finish_run();
  end

endmodule